// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog Timer

This block is a watchdog counter that asks the system reset controller for a reset when software stops servicing it. After every reset it runs with a default setting. Software may replace that setting exactly once through a small option register. The register holds an enable bit, a counting-clock select and a 3-bit timeout code. Software services the watchdog by writing the reset-status register, which arrives here as a single-cycle strobe. If the count reaches the selected limit first, the block raises a one-cycle reset request.

The counter advances either on every bus clock or on rising edges of a slow alternate clock. That alternate clock is brought into the bus clock domain through a synchronizer and an edge detector. While the processor is halted in background debug, the count is held. Entry into either of the two stop modes clears the count and freezes it. After the stop mode ends, counting resumes only once three ticks of the selected clock have passed.

Top module: `cop_watchdog`

## Requirements
- R1: Out of reset the option register reads `cfg_rdata` = 5'b1_0_111 (bit 4 enable = 1, bit 3 clock select = 0, bits 2:0 timeout code = 111), the watchdog runs, and `cop_rst_req` is low.
- R2: Only the first `cfg_wr` after reset loads `cfg_wdata` (same field layout as `cfg_rdata`). Every later write leaves both `cfg_rdata` and the timeout in force unchanged until the next reset.
- R3: Timeout code k in 0..6 selects an overflow after 2^(BASE_LOG2+k) counting ticks. Code 7 selects the same length as code 6. The request appears on the edge that delivers the last of those ticks after a service.
- R4: `cop_rst_req` is high for exactly one bus cycle per overflow. The count then restarts from zero, so the next request follows after another full period.
- R5: With clock select = 1, the count advances only once per rising edge of `alt_clk`, seen through a two-flop synchronizer and an edge detector. Bus cycles alone do not advance it.
- R6: A `svc_wr` strobe clears the count to zero. If it falls in the same cycle as the increment that would overflow, the service wins and no request is made.
- R7: While `dbg_active` is high the count holds its value.
- R8: `stop_enter` clears the count (when enabled) and freezes it until `stop_exit`. After `stop_exit`, three selected-clock ticks pass before the first increment.
- R9: With the enable bit written as 0, the count stays at zero and no reset request is made until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_clk | input | 1 | Slow alternate counting clock, asynchronous to `clk` |
| cfg_wr | input | 1 | Write strobe for the option register |
| cfg_wdata | input | 5 | Option value: {enable, clock select, timeout code[2:0]} |
| cfg_rdata | output | 5 | Current option value, same layout |
| svc_wr | input | 1 | Service strobe from a reset-status register write |
| dbg_active | input | 1 | Background debug active; holds the count |
| stop_enter | input | 1 | One-cycle indication of entry into a stop mode |
| stop_exit | input | 1 | One-cycle indication of exit from a stop mode |
| cop_rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The bench measures the exact bus-cycle distance from a service strobe to the request for several timeout codes. It checks that codes 110 and 111 give the same length. An off-by-one compare or a wrong shift in the decode would show up as a distance error.

Several other faults are caught by targeted scenarios:
- A second option write is checked both through the read-back and through the measured timeout. This catches a lock that can be reopened.
- Services are placed on precisely the overflow cycle. A design that lets the increment win would then fire.
- Debug and stop intervals are inserted and the extra delay is measured. This catches a missing hold, a count not cleared on stop entry, or a restart delay of the wrong length.
- An alternate-clock run must take roughly eight times the bus-clock length, which exposes a clock-select that is ignored.

// File: rtl/cop_wdog_pkg.sv
package cop_wdog_pkg;

  localparam int TSEL_W   = 3;
  localparam int MAX_STEP = 6;
  localparam int CFG_W    = 2 + TSEL_W;

  typedef struct packed {
    logic              en;
    logic              clk_sel;
    logic [TSEL_W-1:0] tsel;
  } cop_cfg_t;

endpackage

// File: rtl/cop_cfg_lock.sv
module cop_cfg_lock
  import cop_wdog_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 5'b1_0_111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output cop_cfg_t         cfg
);

  cop_cfg_t cfg_q;
  logic     locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= cop_cfg_t'(RST_CFG);
      locked_q <= 1'b0;
    end else if (wr && !locked_q) begin
      cfg_q    <= cop_cfg_t'(wdata);
      locked_q <= 1'b1;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/cop_tick_sync.sv
module cop_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic alt_clk,
  output logic tick
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   tick_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= alt_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      prev_q <= sync_q[MSB];
      tick_q <= sync_q[MSB] & ~prev_q;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/cop_run_gate.sv
module cop_run_gate #(
  parameter int RESTART_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic dbg_active,
  input  logic stop_enter,
  input  logic stop_exit,
  output logic run
);

  localparam int DLY_W = $clog2(RESTART_TICKS + 1);

  logic             in_stop_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_stop_q <= 1'b0;
      dly_q     <= '0;
    end else if (stop_enter) begin
      in_stop_q <= 1'b1;
    end else if (stop_exit && in_stop_q) begin
      in_stop_q <= 1'b0;
      dly_q     <= DLY_W'(RESTART_TICKS);
    end else if (!in_stop_q && dly_q != '0 && tick) begin
      dly_q     <= dly_q - 1'b1;
    end
  end

  assign run = !in_stop_q && (dly_q == '0) && !dbg_active;

endmodule

// File: rtl/cop_counter.sv
module cop_counter
  import cop_wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int CNT_W     = BASE_LOG2 + MAX_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              tick,
  input  logic              run,
  input  logic              svc,
  input  logic              stop_clr,
  output logic              req
);

  localparam int CODES = 1 << TSEL_W;

  logic [CNT_W-1:0] term_tbl [CODES];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  generate
    for (genvar k = 0; k < CODES; k++) begin : g_term
      localparam int SH = (k > MAX_STEP) ? MAX_STEP : k;
      assign term_tbl[k] = {CNT_W{1'b1}} >> (MAX_STEP - SH);
    end
  endgenerate

  assign term = term_tbl[tsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!en || svc || stop_clr) begin
        cnt_q <= '0;
      end else if (run && tick) begin
        if (cnt_q == term) begin
          cnt_q <= '0;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req = req_q;

endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_wdog_pkg::*;
#(
  parameter int               BASE_LOG2     = 13,
  parameter int               SYNC_STAGES   = 2,
  parameter int               RESTART_TICKS = 3,
  parameter logic [CFG_W-1:0] RST_CFG       = 5'b1_0_111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alt_clk,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             svc_wr,
  input  logic             dbg_active,
  input  logic             stop_enter,
  input  logic             stop_exit,
  output logic             cop_rst_req
);

  localparam int CNT_W = BASE_LOG2 + MAX_STEP;

  cop_cfg_t cfg;
  logic     alt_tick;
  logic     sel_tick;
  logic     run;

  cop_cfg_lock #(.RST_CFG(RST_CFG)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  cop_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .alt_clk (alt_clk),
    .tick    (alt_tick)
  );

  assign sel_tick = cfg.clk_sel ? alt_tick : 1'b1;

  cop_run_gate #(.RESTART_TICKS(RESTART_TICKS)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .tick       (sel_tick),
    .dbg_active (dbg_active),
    .stop_enter (stop_enter),
    .stop_exit  (stop_exit),
    .run        (run)
  );

  cop_counter #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg.en),
    .tsel     (cfg.tsel),
    .tick     (sel_tick),
    .run      (run),
    .svc      (svc_wr),
    .stop_clr (stop_enter & cfg.en),
    .req      (cop_rst_req)
  );

  assign cfg_rdata = cfg;

endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             svc_wr,
  input logic             dbg_active,
  input logic             stop_enter,
  input logic [4:0]       cfg_rdata,
  input logic             cop_rst_req,
  input logic             locked,
  input logic             in_stop,
  input logic [CNT_W-1:0] cnt
);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg_rdata)); // R2

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cop_rst_req |=> !cop_rst_req); // R4

  AST_SVC_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    svc_wr |=> !cop_rst_req); // R6

  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbg_active && !svc_wr && !stop_enter && cfg_rdata[4]) |=> $stable(cnt)); // R7

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stop_enter && cfg_rdata[4]) |=> (cnt == '0)); // R8

  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (in_stop && !svc_wr && !stop_enter) |=> $stable(cnt)); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[4] |=> (!cop_rst_req && cnt == '0)); // R9

endmodule

bind cop_watchdog cop_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .svc_wr      (svc_wr),
  .dbg_active  (dbg_active),
  .stop_enter  (stop_enter),
  .cfg_rdata   (cfg_rdata),
  .cop_rst_req (cop_rst_req),
  .locked      (u_cfg.locked_q),
  .in_stop     (u_gate.in_stop_q),
  .cnt         (u_cnt.cnt_q)
);

// File: tb/test_cop_watchdog.sv
`timescale 1ns/1ps
module test_cop_watchdog;

  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alt_clk = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic       svc_wr = 1'b0;
  logic       dbg_active = 1'b0;
  logic       stop_enter = 1'b0;
  logic       stop_exit = 1'b0;
  logic       cop_rst_req;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;
  always #20 alt_clk = ~alt_clk;

  cop_watchdog #(.BASE_LOG2(BASE)) i_cop_watchdog (
    .clk(clk), .rst(rst), .alt_clk(alt_clk), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .svc_wr(svc_wr),
    .dbg_active(dbg_active), .stop_enter(stop_enter),
    .stop_exit(stop_exit), .cop_rst_req(cop_rst_req)
  );

  function automatic int period(input int code);
    return 1 << (BASE + ((code > 6) ? 6 : code));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_wr = 1'b0; svc_wr = 1'b0;
    dbg_active = 1'b0; stop_enter = 1'b0; stop_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_cfg(input logic [4:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic service();
    @(negedge clk); svc_wr = 1'b1;
    @(negedge clk); svc_wr = 1'b0;
  endtask

  task automatic measure(input int lim, output int n);
    n = 0;
    while (!cop_rst_req && n < lim) begin
      @(negedge clk);
      n++;
    end
    if (!cop_rst_req) n = -1;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(cfg_rdata == 5'b1_0_111, "R1 reset cfg", cfg_rdata, 5'b1_0_111);
    check(cop_rst_req == 1'b0, "R1 reset req", cop_rst_req, 0);
  endtask

  task automatic t_code(input int code, input bit write_it);
    int n;
    do_reset();
    if (write_it) write_cfg({2'b10, 3'(code)});
    service();
    measure(5000, n);
    check(n == period(code), "R3 timeout length", n, period(code));
  endtask

  task automatic t_pulse_period();
    int n;
    do_reset();
    write_cfg(5'b1_0_000);
    service();
    measure(100, n);
    check(n == 16, "R3 first period", n, 16);
    @(negedge clk);
    check(cop_rst_req == 1'b0, "R4 one-cycle pulse", cop_rst_req, 0);
    measure(100, n);
    check(n + 1 == 16, "R4 next period", n + 1, 16);
  endtask

  task automatic t_write_once();
    int n;
    do_reset();
    write_cfg(5'b1_0_000);
    write_cfg(5'b0_1_011);
    check(cfg_rdata == 5'b1_0_000, "R2 readback", cfg_rdata, 5'b1_0_000);
    service();
    measure(1000, n);
    check(n == 16, "R2 timeout kept", n, 16);
  endtask

  task automatic t_alt_clock();
    int n;
    do_reset();
    write_cfg(5'b1_1_000);
    service();
    measure(1000, n);
    check(n >= 118 && n <= 140, "R5 alt clock rate", n, 128);
  endtask

  task automatic t_service_priority();
    bit seen = 1'b0;
    do_reset();
    write_cfg(5'b1_0_000);
    service();
    for (int r = 0; r < 10; r++) begin
      for (int c = 0; c < 15; c++) begin
        @(negedge clk);
        if (cop_rst_req) seen = 1'b1;
      end
      svc_wr = 1'b1;
      @(negedge clk);
      svc_wr = 1'b0;
      if (cop_rst_req) seen = 1'b1;
    end
    check(!seen, "R6 service on overflow cycle", seen, 0);
  endtask

  task automatic t_debug_hold();
    int n;
    do_reset();
    write_cfg(5'b1_0_000);
    @(negedge clk); svc_wr = 1'b1; dbg_active = 1'b1;
    @(negedge clk); svc_wr = 1'b0;
    repeat (40) @(negedge clk);
    check(cop_rst_req == 1'b0, "R7 held in debug", cop_rst_req, 0);
    dbg_active = 1'b0;
    measure(200, n);
    check(n + 40 == 56, "R7 debug delay", n + 40, 56);
  endtask

  task automatic t_stop_mode();
    int n;
    bit seen = 1'b0;
    do_reset();
    write_cfg(5'b1_0_000);
    service();
    repeat (10) @(negedge clk);
    stop_enter = 1'b1;
    @(negedge clk); stop_enter = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (cop_rst_req) seen = 1'b1;
    end
    check(!seen, "R8 frozen in stop", seen, 0);
    stop_exit = 1'b1;
    @(negedge clk); stop_exit = 1'b0;
    measure(200, n);
    check(n == 19, "R8 clear and restart delay", n, 19);
  endtask

  task automatic t_disabled();
    bit seen = 1'b0;
    do_reset();
    write_cfg(5'b0_0_000);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (cop_rst_req) seen = 1'b1;
    end
    check(!seen, "R9 disabled no request", seen, 0);
    check(cfg_rdata == 5'b0_0_000, "R9 disable readback", cfg_rdata, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(190000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset_state();
    t_code(7, 1'b0);
    t_code(6, 1'b1);
    t_code(0, 1'b1);
    t_code(2, 1'b1);
    t_pulse_period();
    t_write_once();
    t_alt_clock();
    t_service_priority();
    t_debug_hold();
    t_stop_mode();
    t_disabled();
    finish_run();
  end

endmodule